// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits next to the first decode stage and predicts the outcome of branches. Each cycle it takes the fetch address of an instruction, looks it up in a 4-way set-associative table of 256 entries, and returns a hit flag, a taken/not-taken prediction, the stored target, and the address to fetch next. The lookup is purely combinational over registered table state, so the prediction is available in the cycle the address is presented.

When a branch resolves in execute, the pipeline sends back its source address, whether it was actually taken, and its actual target. A resolved branch that is already in the table gets its two-bit saturating history moved one step, and its target refreshed if it was taken. A branch that is not in the table gets an entry only when it resolves as taken, and that entry starts in the strongly-taken state. Victims within a set are picked from invalid ways first, and then by a per-set tree pseudo-LRU.

Pipeline flushing, fetch and execution are outside the block. It produces predictions and keeps its table.

Top module: `btb_predictor`

## Requirements
- R1: The table has 64 sets of 4 ways. The set index is address bits [7:2], and the tag is bits [31:8]. An entry matches only a lookup with both the same set and the same tag. At most one way of a set hits.
- R2: After reset, every lookup misses until an entry has been allocated.
- R3: On a miss, `pred_taken` is 0 and `next_fetch` equals `lkp_addr + 4`, even for branches that always jump.
- R4: A taken resolution that misses allocates an entry with history 11 and the given target. A lookup of that address afterwards hits, predicts taken and returns the target.
- R5: A not-taken resolution that misses leaves the table unchanged, so a later lookup of that address still misses.
- R6: The history is 2 bits: 11 strong taken, 10 weak taken, 01 weak not-taken, 00 strong not-taken. Bit 1 set means the entry predicts taken. A taken resolution on a hit steps the history up and saturates at 11. A not-taken resolution steps it down and saturates at 00.
- R7: On a hit, `pred_target` is the stored target. `next_fetch` is that target when the prediction is taken, and `lkp_addr + 4` otherwise.
- R8: A taken resolution that hits replaces the stored target with the resolved target.
- R9: Allocation uses the lowest-numbered invalid way of the set first, so four distinct branches in one set all stay resident.
- R10: In a full set, the victim comes from a 3-bit tree pseudo-LRU per set, all zero at reset. Bit 0 selects the half (0: ways 0–1, 1: ways 2–3). Bit 1 selects within ways 0–1, and bit 2 selects within ways 2–3. Touching way w sets bit 0 to the inverse of w[1], and sets the bit for w's half to the inverse of w[0]. A lookup hit with `lkp_valid` high touches the way. Then an update hit or an allocation touches its way.
- R11: When a lookup and an update address the same entry in one cycle, the lookup returns the state from before that update. The update is visible from the next cycle.
- R12: Reset is asynchronous and active low. Its release takes effect after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup is real; gates pseudo-LRU touch on hit |
| lkp_addr | input | 32 | Fetch address of the instruction in decode |
| pred_hit | output | 1 | Lookup address is present in the table |
| pred_taken | output | 1 | Predicted taken (hit and history bit 1 set) |
| pred_target | output | 32 | Stored target of the hitting entry, zero on miss |
| next_fetch | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolution is presented this cycle |
| upd_addr | input | 32 | Source address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target address |

## Verification
A wrong history step appears at `pred_taken` on the first lookup after the offending update. It shows up at once for a state that crosses the 10/01 boundary, and otherwise one further resolution later. A bad tag, valid or target write shows as a wrong `pred_hit` or `next_fetch` in the cycle after the write. A faulty pseudo-LRU state stays hidden until the set is full and the next allocation evicts the wrong branch. The evicted branch then misses, and a survivor that should have gone keeps hitting, on the next lookup of each.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef logic [1:0] hist_t;
  typedef logic [2:0] plru_t;

  localparam hist_t HIST_STRONG_T  = 2'b11;
  localparam hist_t HIST_STRONG_NT = 2'b00;

  // Saturating two-bit step toward the resolved outcome.
  function automatic hist_t hist_step(hist_t h, logic taken);
    hist_t r;
    if (taken) r = (h == HIST_STRONG_T)  ? h : h + 2'd1;
    else       r = (h == HIST_STRONG_NT) ? h : h - 2'd1;
    return r;
  endfunction

  // Point the tree away from the touched way.
  function automatic plru_t plru_touch(plru_t s, logic [WAY_W-1:0] w);
    plru_t r;
    r    = s;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else       r[2] = ~w[0];
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(plru_t s);
    logic [WAY_W-1:0] v;
    if (s[0]) v = {1'b1, s[2]};
    else      v = {1'b0, s[1]};
    return v;
  endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 6,
  parameter int TAG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lkp_set,
  input  logic [TAG_W-1:0]  lkp_tag,
  input  logic [SET_W-1:0]  upd_set,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_target,
  output logic              lkp_hit,
  output hist_t             lkp_hist,
  output logic [ADDR_W-1:0] lkp_target,
  output logic              upd_hit,
  output logic              upd_occupied
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q, valid_d;
  hist_t             hist_q [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [ADDR_W-1:0] tgt_q  [SETS];

  hist_t hist_wr;
  logic  tgt_we;

  // Read ports
  assign lkp_hit      = valid_q[lkp_set] && (tag_q[lkp_set] == lkp_tag);
  assign lkp_hist     = hist_q[lkp_set];
  assign lkp_target   = tgt_q[lkp_set];
  assign upd_hit      = valid_q[upd_set] && (tag_q[upd_set] == upd_tag);
  assign upd_occupied = valid_q[upd_set];

  // Next-state
  always_comb begin
    valid_d = valid_q;
    if (wr_en && wr_alloc) valid_d[upd_set] = 1'b1;
    hist_wr = wr_alloc ? HIST_STRONG_T : hist_step(hist_q[upd_set], wr_taken);
    tgt_we  = wr_en && (wr_alloc || wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Data arrays: no reset, written under explicit enables.
  always_ff @(posedge clk) begin
    if (wr_en)            hist_q[upd_set] <= hist_wr;
    if (wr_en && wr_alloc) tag_q[upd_set] <= upd_tag;
    if (tgt_we)            tgt_q[upd_set] <= wr_target;
  end

  assert_alloc_strong_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_alloc) |=>
      (valid_q[$past(upd_set)] && hist_q[$past(upd_set)] == HIST_STRONG_T));

  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_alloc && wr_taken && hist_q[upd_set] == HIST_STRONG_T) |=>
      (hist_q[$past(upd_set)] == HIST_STRONG_T));

  assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_alloc && !wr_taken && hist_q[upd_set] == HIST_STRONG_NT) |=>
      (hist_q[$past(upd_set)] == HIST_STRONG_NT));

endmodule

// File: rtl/btb_plru.sv
module btb_plru
  import btb_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_touch,
  input  logic [SET_W-1:0] lkp_set,
  input  logic [WAY_W-1:0] lkp_way,
  input  logic             upd_touch,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  output logic [WAY_W-1:0] upd_victim
);

  localparam int SETS = 1 << SET_W;

  plru_t state_q [SETS];
  plru_t state_d [SETS];

  assign upd_victim = plru_victim(state_q[upd_set]);

  // Lookup touch first, update touch last, so that same-set accesses compose.
  always_comb begin
    for (int s = 0; s < SETS; s++) state_d[s] = state_q[s];
    if (lkp_touch) state_d[lkp_set] = plru_touch(state_d[lkp_set], lkp_way);
    if (upd_touch) state_d[upd_set] = plru_touch(state_d[upd_set], upd_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) state_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) state_q[s] <= state_d[s];
    end
  end

  assert_plru_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_touch |=> (plru_victim(state_q[$past(upd_set)]) != $past(upd_way)));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 6,
  parameter int OFS_W  = 2,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] next_fetch,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int TAG_W = ADDR_W - SET_W - OFS_W;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SET_W-1:0] lkp_set, upd_set;
  logic [TAG_W-1:0] lkp_tag, upd_tag;

  assign lkp_set = lkp_addr[OFS_W +: SET_W];
  assign upd_set = upd_addr[OFS_W +: SET_W];
  assign lkp_tag = lkp_addr[ADDR_W-1 -: TAG_W];
  assign upd_tag = upd_addr[ADDR_W-1 -: TAG_W];

  logic [NUM_WAYS-1:0] lkp_hit_vec, upd_hit_vec, upd_occ_vec, wr_en_vec;
  hist_t               way_hist [NUM_WAYS];
  logic [ADDR_W-1:0]   way_tgt  [NUM_WAYS];

  logic             alloc_need, any_free, upd_hit;
  logic [WAY_W-1:0] lkp_way, upd_hit_way, free_way, victim_way, alloc_way;
  hist_t            sel_hist;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    btb_way #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_way (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .lkp_set      (lkp_set),
      .lkp_tag      (lkp_tag),
      .upd_set      (upd_set),
      .upd_tag      (upd_tag),
      .wr_en        (wr_en_vec[w]),
      .wr_alloc     (alloc_need),
      .wr_taken     (upd_taken),
      .wr_target    (upd_target),
      .lkp_hit      (lkp_hit_vec[w]),
      .lkp_hist     (way_hist[w]),
      .lkp_target   (way_tgt[w]),
      .upd_hit      (upd_hit_vec[w]),
      .upd_occupied (upd_occ_vec[w])
    );
  end

  // Lookup side: one-hot select of the hitting way.
  always_comb begin
    sel_hist    = '0;
    pred_target = '0;
    lkp_way     = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (lkp_hit_vec[w]) begin
        sel_hist    = sel_hist | way_hist[w];
        pred_target = pred_target | way_tgt[w];
        lkp_way     = lkp_way | WAY_W'(w);
      end
    end
  end

  assign pred_hit   = |lkp_hit_vec;
  assign pred_taken = pred_hit && sel_hist[1];
  assign next_fetch = pred_taken ? pred_target : lkp_addr + ADDR_W'(STEP);

  // Update side: hit way, first free way, replacement victim.
  always_comb begin
    upd_hit_way = '0;
    free_way    = '0;
    any_free    = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (upd_hit_vec[w]) upd_hit_way = upd_hit_way | WAY_W'(w);
    end
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!upd_occ_vec[w]) begin
        free_way = WAY_W'(w);
        any_free = 1'b1;
      end
    end
  end

  assign upd_hit    = |upd_hit_vec;
  assign alloc_need = upd_valid && !upd_hit && upd_taken;
  assign alloc_way  = any_free ? free_way : victim_way;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      wr_en_vec[w] = (upd_valid && upd_hit_vec[w]) ||
                     (alloc_need && alloc_way == WAY_W'(w));
    end
  end

  btb_plru #(.SET_W(SET_W)) u_plru (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lkp_touch  (lkp_valid && pred_hit),
    .lkp_set    (lkp_set),
    .lkp_way    (lkp_way),
    .upd_touch  (upd_valid && (upd_hit || upd_taken)),
    .upd_set    (upd_set),
    .upd_way    (upd_hit ? upd_hit_way : alloc_way),
    .upd_victim (victim_way)
  );

  logic unused_bits;
  assign unused_bits = ^{lkp_addr[OFS_W-1:0], upd_addr[OFS_W-1:0], sel_hist[0]};

  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($onehot0(lkp_hit_vec) && $onehot0(upd_hit_vec)));

  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_en_vec));

endmodule

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_valid, upd_valid, upd_taken;
  logic [31:0] lkp_addr, upd_addr, upd_target;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target, next_fetch;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_target(pred_target), .next_fetch(next_fetch),
    .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic logic [31:0] mk(logic [23:0] tag, logic [5:0] set);
    return {tag, set, 2'b00};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic resolve(logic [31:0] a, logic t, logic [31:0] tgt);
    upd_valid = 1'b1; upd_addr = a; upd_taken = t; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic expect_lkp(logic [31:0] a, logic hit, logic tk,
                            logic [31:0] tgt, string req);
    logic [31:0] nf;
    lkp_valid = 1'b1; lkp_addr = a;
    #1;
    nf = (hit && tk) ? tgt : a + 32'd4;
    chk(pred_hit == hit, req, {31'b0, pred_hit}, {31'b0, hit});
    chk(pred_taken == (hit && tk), req, {31'b0, pred_taken}, {31'b0, hit && tk});
    if (hit) chk(pred_target == tgt, req, pred_target, tgt);
    chk(next_fetch == nf, req, next_fetch, nf);
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lkp_valid = 0; upd_valid = 0; upd_taken = 0;
    lkp_addr = '0; upd_addr = '0; upd_target = '0;
    repeat (3) @(negedge clk);
    lkp_addr = 32'h0000_1234; #1;
    chk(!pred_hit, "R12 in reset", {31'b0, pred_hit}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_lkp(32'h0000_1234, 0, 0, 0, "R2 empty after reset");
    expect_lkp(32'hFFFF_FFFC, 0, 0, 0, "R2 empty top address");
  endtask

  task automatic t_miss();
    logic [31:0] a = mk(24'h00A001, 6'd3);
    expect_lkp(a, 0, 0, 0, "R3 miss predicts sequential");
    resolve(a, 1'b0, 32'h0000_9000);
    expect_lkp(a, 0, 0, 0, "R5 not-taken miss leaves table");
  endtask

  task automatic t_alloc();
    logic [31:0] a = mk(24'h00A001, 6'd3);
    resolve(a, 1'b1, 32'h0000_9000);
    expect_lkp(a, 1, 1, 32'h0000_9000, "R4 allocate strong taken");
    expect_lkp(mk(24'h00A001, 6'd4), 0, 0, 0, "R1 other set misses");
    expect_lkp(mk(24'h00A002, 6'd3), 0, 0, 0, "R1 other tag misses");
  endtask

  task automatic t_history();
    logic [31:0] a = mk(24'h00A001, 6'd3);
    logic [31:0] g = 32'h0000_9000;
    resolve(a, 0, g); expect_lkp(a, 1, 1, g, "R6 11->10 taken");
    resolve(a, 0, g); expect_lkp(a, 1, 0, g, "R7 10->01 hit not taken");
    resolve(a, 0, g); expect_lkp(a, 1, 0, g, "R6 01->00");
    resolve(a, 0, g); expect_lkp(a, 1, 0, g, "R6 saturate 00");
    resolve(a, 1, g); expect_lkp(a, 1, 0, g, "R6 00->01 not taken");
    resolve(a, 1, g); expect_lkp(a, 1, 1, g, "R6 01->10 taken");
    resolve(a, 1, g); resolve(a, 1, g);
    resolve(a, 0, g); expect_lkp(a, 1, 1, g, "R6 saturate 11 then 10");
  endtask

  task automatic t_retarget();
    logic [31:0] a = mk(24'h00A001, 6'd3);
    resolve(a, 1, 32'h0000_7700);
    expect_lkp(a, 1, 1, 32'h0000_7700, "R8 new target");
  endtask

  task automatic t_same_cycle();
    logic [31:0] a = mk(24'h00A001, 6'd3);
    // History is 11 after t_retarget; bring it to 10.
    resolve(a, 0, 32'h0000_7700);
    lkp_valid = 1; lkp_addr = a;
    upd_valid = 1; upd_addr = a; upd_taken = 0; upd_target = 32'h0000_7700;
    #1;
    chk(pred_taken == 1'b1, "R11 pre-write state seen", {31'b0, pred_taken}, 32'd1);
    @(negedge clk);
    lkp_valid = 0; upd_valid = 0;
    expect_lkp(a, 1, 0, 32'h0000_7700, "R11 write visible next cycle");
  endtask

  task automatic t_replace();
    logic [5:0]  s = 6'd9;
    logic [31:0] ta = 32'h1000_0000;
    for (int i = 0; i < 4; i++) resolve(mk(24'h100 + 24'(i), s), 1, ta + 32'(i));
    for (int i = 0; i < 4; i++)
      expect_lkp(mk(24'h100 + 24'(i), s), 1, 1, ta + 32'(i), "R9 four ways resident");
    // Tree now points at way 0 (first branch): it is the victim.
    resolve(mk(24'h104, s), 1, ta + 32'd4);
    expect_lkp(mk(24'h100, s), 0, 0, 0, "R10 LRU way evicted");
    for (int i = 1; i < 5; i++)
      expect_lkp(mk(24'h100 + 24'(i), s), 1, 1, ta + 32'(i), "R10 survivors hit");
    // Touches 1,2,3,0 leave bit0=1, bit2=0: victim is way 2 (third branch).
    resolve(mk(24'h105, s), 1, ta + 32'd5);
    expect_lkp(mk(24'h102, s), 0, 0, 0, "R10 second victim");
    expect_lkp(mk(24'h105, s), 1, 1, ta + 32'd5, "R10 new entry hits");
    expect_lkp(mk(24'h101, s), 1, 1, ta + 32'd1, "R10 recent way kept");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_miss();
    t_alloc();
    t_history();
    t_retarget();
    t_same_cycle();
    t_replace();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule